// File: doc/BRIEF.md
# Polled Byte SPI Master

This block is a small SPI master for a serial flash device. It sits behind a simple CPU register port and moves one byte at a time. Software controls the chip select directly through an enable register. It loads a byte into a data register, starts the transfer with a write to a control address, and polls that same address until it reads nonzero. It then reads the byte that came back on MISO from the data address.

Longer flash commands are built in software by holding chip select low and repeating the load, start and poll steps. To read data back, software sends dummy bytes. The serial clock follows SPI mode 0:

- SCK idles low.
- MOSI changes after each falling edge.
- MISO is sampled on each rising edge.
- Bits move most significant first.
- Each half period of SCK lasts a fixed number of system clocks, set by a parameter.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, csn_o is 1 and sck_o is 0. A read of address 0x81 returns 1, and a read of address 0x82 returns 0.
- R2: A write to address 0x80 copies wdata_i[0] to the enable bit. csn_o is driven to the inverse of the enable bit, and a read of 0x80 returns the enable bit in bit 0.
- R3: A write to address 0x81 while the master is idle starts one transfer, whatever data is written. The transfer has exactly eight SCK high pulses, and SCK is low whenever the master is idle.
- R4: A read of address 0x81 returns 1 when idle and 0 while busy. The master reads busy from the clock edge that takes the start write until 16*CLK_DIV+1 clock edges later.
- R5: The byte sent on mosi_o is bits [7:0] of the last write to address 0x82 before the start, most significant bit first. mosi_o does not change while sck_o is high.
- R6: miso_i is sampled on each rising SCK edge, most significant bit first. After the transfer ends, a read of 0x82 returns the received byte in bits [7:0] with the upper bits zero.
- R7: A write to address 0x81 while a transfer is in progress is ignored. The transfer keeps its length and its data.
- R8: Each SCK level lasts CLK_DIV system clocks. The first rising edge comes CLK_DIV clock edges after the start edge.
- R9: A write to address 0x82 during a transfer does not change the byte being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data, combinational from addr_i |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |
| csn_o | output | 1 | Active-low chip select |

## Verification
A fault in the shift state machine or the bit counter shows up as a status poll that returns ready too early or too late. The bench checks the busy length to the exact clock edge, so a wrong count is caught within the first transfer. A divider fault moves the first rising SCK edge away from CLK_DIV edges after the start, which is visible a few cycles in. Shift-order or sampling-edge faults corrupt the byte seen by the bench's flash model or the byte read back at 0x82 once the transfer completes.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam logic [7:0] ADDR_ENABLE = 8'h80;
  localparam logic [7:0] ADDR_XFER   = 8'h81;
  localparam logic [7:0] ADDR_DATA   = 8'h82;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          reached;

  assign reached = (cnt_q == LAST);
  assign tick_o  = run_i && reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (reached)     cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_byte_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       run_o,
  output logic       busy_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o
);
  xfer_state_e state_q;
  logic [7:0]  tx_sh_q;
  logic [7:0]  rx_sh_q;
  logic [7:0]  rx_q;
  logic [2:0]  bit_q;
  logic        sck_q;

  assign run_o  = (state_q == ST_SHIFT);
  assign busy_o = (state_q != ST_IDLE);
  assign sck_o  = sck_q;
  assign mosi_o = tx_sh_q[7];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SHIFT;
            tx_sh_q <= tx_i;
            bit_q   <= '0;
            sck_q   <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            if (!sck_q) begin
              // rising edge: sample
              sck_q   <= 1'b1;
              rx_sh_q <= {rx_sh_q[6:0], miso_i};
            end else begin
              // falling edge: advance
              sck_q   <= 1'b0;
              tx_sh_q <= {tx_sh_q[6:0], 1'b0};
              bit_q   <= bit_q + 1'b1;
              if (bit_q == 3'd7) begin
                state_q <= ST_DONE;
                rx_q    <= rx_sh_q;
              end
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_byte_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic [7:0]        rx_i,
  output logic              start_o,
  output logic [7:0]        tx_o,
  output logic              en_o
);
  logic       en_q;
  logic [7:0] tx_q;
  logic       hit_en, hit_xfer, hit_data;
  logic       unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:8];

  assign hit_en   = (addr_i == ADDR_W'(ADDR_ENABLE));
  assign hit_xfer = (addr_i == ADDR_W'(ADDR_XFER));
  assign hit_data = (addr_i == ADDR_W'(ADDR_DATA));

  assign start_o = we_i && hit_xfer;
  assign tx_o    = tx_q;
  assign en_o    = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      tx_q <= '0;
    end else if (we_i) begin
      if (hit_en)   en_q <= wdata_i[0];
      if (hit_data) tx_q <= wdata_i[7:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_en)        rdata_o[0]   = en_q;
    else if (hit_xfer) rdata_o[0]   = !busy_i;
    else if (hit_data) rdata_o[7:0] = rx_i;
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              csn_o
);
  logic       start, tick, run, busy, en;
  logic [7:0] tx_byte, rx_byte;

  spi_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .busy_i  (busy),
    .rx_i    (rx_byte),
    .start_o (start),
    .tx_o    (tx_byte),
    .en_o    (en)
  );

  spi_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  spi_shift_engine u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tx_i    (tx_byte),
    .tick_i  (tick),
    .miso_i  (miso_i),
    .run_o   (run),
    .busy_o  (busy),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .rx_o    (rx_byte)
  );

  assign csn_o = !en;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_byte_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              sck_o,
  input logic              mosi_o,
  input logic              csn_o,
  input logic              busy
);
  localparam int GW = $clog2(CLK_DIV + 2) + 1;

  logic [GW-1:0] gap_q;
  logic          sck_prev_q;
  logic          wr_xfer, wr_en;

  assign wr_xfer = we_i && (addr_i == ADDR_W'(ADDR_XFER));
  assign wr_en   = we_i && (addr_i == ADDR_W'(ADDR_ENABLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_o;
      if (!busy)                    gap_q <= '0;
      else if (sck_o != sck_prev_q) gap_q <= GW'(1);
      else                          gap_q <= gap_q + 1'b1;
    end
  end

  // R3
  sck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o);

  // R4
  start_goes_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_xfer && !busy) |=> busy);

  // R5
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  // R2
  csn_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (csn_o == !$past(wdata_i[0])));

  // R8
  half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (sck_o != sck_prev_q)) |-> (gap_q == GW'(CLK_DIV)));
endmodule

bind spi_byte_master spi_byte_master_chk #(
  .CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .sck_o   (sck_o),
  .mosi_o  (mosi_o),
  .csn_o   (csn_o),
  .busy    (busy)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int BUSY_LEN   = 16 * DIV + 1;
  localparam int NVEC       = 6;
  // {byte written to 0x82, byte returned by flash model}
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, csn;
  logic        miso = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int rises = 0;
  logic [7:0] fl_out = '0;
  logic [7:0] fl_cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master #(.CLK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .csn_o(csn)
  );

  // flash model, mode 0
  always @(posedge sck) begin
    fl_cap = {fl_cap[6:0], mosi};
    rises  = rises + 1;
  end
  always @(negedge sck) begin
    fl_out = {fl_out[6:0], 1'b0};
    miso   = fl_out[7];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 8'h00; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // one transfer; optional write (poke) at busy cycle poke_k
  task automatic xfer(input logic [7:0] tx, input logic [7:0] fl, input int poke_k,
                      input logic [7:0] poke_a, input logic [31:0] poke_d, input string tag);
    int k;
    int first_rise;
    logic [31:0] st;
    logic [31:0] rx;
    wr(8'h82, {24'hDEAD_BE, tx});
    fl_out = fl; miso = fl[7]; fl_cap = '0; rises = 0;
    wr(8'h81, 32'h0);
    k = 0; first_rise = -1;
    forever begin
      if (sck && first_rise < 0) first_rise = k;
      if (k == poke_k) begin
        we = 1'b1; addr = poke_a; wdata = poke_d;
      end else begin
        we = 1'b0;
        rd(8'h81, st);
        if (st != 0) break;
        if (k > 4 * BUSY_LEN) break;
      end
      @(negedge clk);
      we = 1'b0;
      k++;
    end
    // R4 busy length
    check({"R4 busy length ", tag}, k, BUSY_LEN);
    // R8 first rising edge timing
    check({"R8 first rise ", tag}, first_rise, DIV);
    // R3 eight pulses
    check({"R3 pulses ", tag}, rises, 8);
    check({"R3 sck idle ", tag}, sck, 1'b0);
    // R5 flash saw transmitted byte
    check({"R5 mosi byte ", tag}, fl_cap, tx);
    // R6 received byte
    rd(8'h82, rx);
    check({"R6 rx byte ", tag}, rx, {24'h0, fl});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 csn", csn, 1'b1);
    check("R1 sck", sck, 1'b0);
    rd(8'h81, v); check("R1 ready", v, 32'h1);
    rd(8'h82, v); check("R1 rx", v, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 chip select control
    wr(8'h80, 32'h1);
    check("R2 csn low", csn, 1'b0);
    rd(8'h80, v); check("R2 readback", v, 32'h1);
    wr(8'h80, 32'h0);
    check("R2 csn high", csn, 1'b1);
    rd(8'h80, v); check("R2 readback0", v, 32'h0);
    wr(8'h80, 32'h1);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i][15:8], VEC[i][7:0], -1, 8'h00, 32'h0, $sformatf("vec%0d", i));
    end

    // R7 start while busy ignored
    xfer(8'h6B, 8'h94, 3 * DIV, 8'h81, 32'hFFFF_FFFF, "r7_restart");
    // R9 data write while busy does not alter shift
    xfer(8'hC6, 8'h39, 10, 8'h82, 32'h0000_0011, "r9_datawrite");
    rd(8'h82, v); check("R9 rx unchanged by tx write", v, 32'h39);

    // R2 csn stayed low through transfers
    check("R2 csn held", csn, 1'b0);
    wr(8'h80, 32'h0);
    check("R2 csn released", csn, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule